// File: doc/BRIEF.md
# Extend and Logical Execute Unit

This block is a single-cycle execute stage that owns a 32-entry, 32-bit register file and a four-bit flag set: carry, overflow, sign and zero. It takes one 16-bit opcode per clock, with an optional 16-bit immediate halfword beside it. From the opcode it carries out one of seven operations:

- four width extensions that rewrite a single register in place;
- a register-to-register XOR;
- an XOR with a zero-extended immediate;
- an AND that only updates flags.

Every operation finishes in one clock. Its result can be read through the read port, and its flags seen on the flag outputs, in the cycle after issue.

Other parts of the core share the register file and flags through two side ports:

- a register load port, which writes a value from elsewhere, such as a memory pipeline;
- a flag load port.

A combinational read port lets any register be observed. Register 0 is hard-wired to zero.

Top module: `ext_logic_unit`

## Requirements
- R1: Opcodes with bits 15:5 equal to 00000000100 (byte) or 00000000110 (halfword) replace the register named in bits 4:0 with its own low 8 or 16 bits, zero-extended.
- R2: Opcodes with bits 15:5 equal to 00000000101 (byte) or 00000000111 (halfword) replace the register named in bits 4:0 with its own low 8 or 16 bits, sign-extended.
- R3: An opcode with bits 10:5 = 001001 writes the XOR of the registers named by bits 15:11 and bits 4:0 into the register named by bits 15:11.
- R4: An opcode with bits 10:5 = 110101 writes the register named by bits 4:0, XORed with the immediate halfword zero-extended to 32 bits, into the register named by bits 15:11.
- R5: An opcode with bits 10:5 = 001011 forms the AND of the two named registers for the flags only and leaves every register unchanged.
- R6: After R3, R4 and R5, overflow is 0, sign equals bit 31 of the result, zero is 1 exactly when the result is 0, and carry keeps its previous value.
- R7: The four extend operations leave all four flags unchanged.
- R8: Register 0 always reads as zero, both as an operand and on the read port. Writes to it from an instruction or from the load port are discarded.
- R9: Each operation takes one clock. Its register and flag effects are visible, and `op_done` is 1, in the cycle after `issue_valid`. An opcode that matches none of R1 to R5 changes nothing and leaves `op_done` at 0.
- R10: The load ports write one register or the whole flag set, in the order {carry, overflow, sign, zero}. When an instruction writes the same register, or updates flags, in the same cycle, the instruction result is kept and the load for that target is dropped.
- R11: Reset clears all registers, all flags and `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An opcode is presented this cycle |
| issue_op | input | 16 | Opcode halfword |
| issue_imm | input | 16 | Immediate halfword (used by the immediate XOR only) |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 5 | Register load index |
| ld_data | input | 32 | Register load value |
| psw_ld_en | input | 1 | Flag load strobe |
| psw_ld_data | input | 4 | Flag load value {cy, ov, s, z} |
| rd_sel | input | 5 | Read port index |
| rd_data | output | 32 | Read port value (combinational) |
| op_done | output | 1 | A recognised operation completed last cycle |
| flag_cy | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
A wrong register-file entry shows on `rd_data` as soon as the bench points the read port at it. The bench moves the read index every cycle, so a bad write is exposed within one clock of the operation that made it, or at the latest when that register is next used as an operand. A wrong flag appears on the flag outputs in the very next cycle. The same applies to a carry that was touched when it should have been kept, and to an overflow left set.

Decode errors show in two ways. The wrong destination is written, or a register is written by the flag-only AND. Either can be seen on the read port. A decode error can also leave `op_done` wrong for unrecognised opcodes, which is visible in the following cycle.

// File: rtl/ext_logic_unit.sv
module ext_logic_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [15:0]     issue_op,
  input  logic [15:0]     issue_imm,
  input  logic            ld_en,
  input  logic [4:0]      ld_sel,
  input  logic [XLEN-1:0] ld_data,
  input  logic            psw_ld_en,
  input  logic [3:0]      psw_ld_data,
  input  logic [4:0]      rd_sel,
  output logic [XLEN-1:0] rd_data,
  output logic            op_done,
  output logic            flag_cy,
  output logic            flag_ov,
  output logic            flag_s,
  output logic            flag_z
);
  localparam int NREG = 32;
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] gr [NREG];

  wire [4:0] f_lo  = issue_op[4:0];
  wire [4:0] f_hi  = issue_op[15:11];
  wire [5:0] f_sub = issue_op[10:5];

  wire do_ext  = issue_valid && f_hi == 5'd0 && f_sub[5:2] == 4'b0001;
  wire do_xor  = issue_valid && f_sub == 6'b001001;
  wire do_tst  = issue_valid && f_sub == 6'b001011;
  wire do_xori = issue_valid && f_sub == 6'b110101;
  wire do_flag = do_xor || do_xori || do_tst;

  wire [XLEN-1:0] opa = (f_lo == 5'd0) ? '0 : gr[f_lo];
  wire [XLEN-1:0] opb = (f_hi == 5'd0) ? '0 : gr[f_hi];

  logic [XLEN-1:0] ext_res, log_res;

  always_comb begin
    unique case (f_sub[1:0])
      2'b00:   ext_res = {{(XLEN-8){1'b0}}, opa[7:0]};
      2'b01:   ext_res = {{(XLEN-8){opa[7]}}, opa[7:0]};
      2'b10:   ext_res = {{(XLEN-HALF){1'b0}}, opa[HALF-1:0]};
      default: ext_res = {{(XLEN-HALF){opa[HALF-1]}}, opa[HALF-1:0]};
    endcase
  end

  always_comb begin
    if (do_xori)     log_res = opa ^ {{(XLEN-16){1'b0}}, issue_imm};
    else if (do_tst) log_res = opb & opa;
    else             log_res = opb ^ opa;
  end

  wire            wr_en  = do_ext || do_xor || do_xori;
  wire [4:0]      wr_sel = do_ext ? f_lo : f_hi;
  wire [XLEN-1:0] wr_val = do_ext ? ext_res : log_res;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n || i == 0)
        gr[i] <= '0;
      else if (wr_en && wr_sel == 5'(i))
        gr[i] <= wr_val;
      else if (ld_en && ld_sel == 5'(i))
        gr[i] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {flag_cy, flag_ov, flag_s, flag_z} <= 4'b0;
      op_done <= 1'b0;
    end else begin
      op_done <= do_ext || do_flag;
      if (do_flag) begin
        flag_ov <= 1'b0;
        flag_s  <= log_res[XLEN-1];
        flag_z  <= log_res == '0;
      end else if (psw_ld_en) begin
        {flag_cy, flag_ov, flag_s, flag_z} <= psw_ld_data;
      end
    end
  end

  assign rd_data = (rd_sel == 5'd0) ? '0 : gr[rd_sel];
endmodule

module ext_logic_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [15:0]     issue_op,
  input logic            psw_ld_en,
  input logic            ld_en,
  input logic [4:0]      rd_sel,
  input logic [XLEN-1:0] rd_data,
  input logic            op_done,
  input logic            flag_cy,
  input logic            flag_ov,
  input logic            flag_s,
  input logic            flag_z
);
  wire logic_op = issue_valid && (issue_op[10:5] == 6'b001001 ||
                  issue_op[10:5] == 6'b110101 || issue_op[10:5] == 6'b001011);
  wire ext_op = issue_valid && issue_op[15:11] == 5'd0 && issue_op[10:7] == 4'b0001;
  wire tst_op = issue_valid && issue_op[10:5] == 6'b001011;

  // R6
  ov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_op |=> !flag_ov);
  // R6
  cy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_op |=> $stable(flag_cy));
  // R7
  ext_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_op && !psw_ld_en) |=> $stable({flag_cy, flag_ov, flag_s, flag_z}));
  // R5
  tst_noreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_op && !ld_en) |=> ($stable(rd_sel) -> $stable(rd_data)));
  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> $past(issue_valid));
  // R9
  done_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_op || ext_op) |=> op_done);
endmodule

bind ext_logic_unit ext_logic_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
  .psw_ld_en(psw_ld_en), .ld_en(ld_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .op_done(op_done), .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s),
  .flag_z(flag_z)
);

// File: tb/ext_logic_unit_bench.sv
module ext_logic_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        issue_valid = 0;
  logic [15:0] issue_op = 0, issue_imm = 0;
  logic        ld_en = 0;
  logic [4:0]  ld_sel = 0;
  logic [31:0] ld_data = 0;
  logic        psw_ld_en = 0;
  logic [3:0]  psw_ld_data = 0;
  logic [4:0]  rd_sel = 0;
  logic [31:0] rd_data;
  logic        op_done, flag_cy, flag_ov, flag_s, flag_z;

  ext_logic_unit u_ext_logic_unit (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] m_gr [32];
  logic [3:0]  m_fl;
  logic        m_done;
  string       cur_tag = "R11", prev_tag = "R11";

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_gr[i] = 0;
      m_fl = 0; m_done = 0;
    end else begin
      logic [31:0] a, b, r;
      logic [5:0] sub;
      bit ext, lg, wr;
      int dst;
      a = m_gr[issue_op[4:0]];
      b = m_gr[issue_op[15:11]];
      sub = issue_op[10:5];
      ext = issue_valid && issue_op[15:11] == 0 && sub >= 4 && sub <= 7;
      lg = issue_valid && (sub == 9 || sub == 11 || sub == 53);
      wr = 0; dst = 0; r = 0;
      if (ext) begin
        case (sub)
          4: r = 32'(a[7:0]);
          5: r = 32'(signed'(a[7:0]));
          6: r = 32'(a[15:0]);
          default: r = 32'(signed'(a[15:0]));
        endcase
        wr = 1; dst = issue_op[4:0];
      end else if (lg) begin
        if (sub == 9) begin r = a ^ b; wr = 1; end
        else if (sub == 53) begin r = a ^ {16'h0, issue_imm}; wr = 1; end
        else r = a & b;
        dst = issue_op[15:11];
      end
      if (ld_en && !(wr && dst == ld_sel)) m_gr[ld_sel] = ld_data;
      if (wr) m_gr[dst] = r;
      m_gr[0] = 0;
      if (lg) m_fl = {m_fl[3], 1'b0, r[31], r == 0};
      else if (psw_ld_en) m_fl = psw_ld_data;
      m_done = ext || lg;
    end
  end

  task automatic compare();
    logic [37:0] got, exp;
    got = {rd_data, flag_cy, flag_ov, flag_s, flag_z, op_done, 1'b0};
    exp = {m_gr[rd_sel], m_fl, m_done, 1'b0};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rd[%0d]/flags/done got %h expected %h", prev_tag, rd_sel, got, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [15:0] op, input logic [15:0] imm,
                     input bit le, input logic [4:0] ls, input logic [31:0] ld,
                     input bit pe, input logic [3:0] pd, input logic [4:0] rs,
                     input string tag);
    @(negedge clk);
    compare();
    prev_tag = cur_tag;
    cur_tag = tag;
    issue_valid = v; issue_op = op; issue_imm = imm;
    ld_en = le; ld_sel = ls; ld_data = ld;
    psw_ld_en = pe; psw_ld_data = pd; rd_sel = rs;
  endtask

  function automatic logic [15:0] op_ext(int kind, int r);
    return {11'(4 + kind), 5'(r)};
  endfunction
  function automatic logic [15:0] op_rr(logic [5:0] sub, int r1, int r2);
    return {5'(r2), sub, 5'(r1)};
  endfunction

  task automatic load(int r, logic [31:0] v, string tag);
    cyc(0, 0, 0, 1, 5'(r), v, 0, 0, 5'(r), tag);
  endtask
  task automatic exec(logic [15:0] op, logic [15:0] imm, int rs, string tag);
    cyc(1, op, imm, 0, 0, 0, 0, 0, 5'(rs), tag);
  endtask
  task automatic idle(int rs, string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 5'(rs), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({rd_data, flag_cy, flag_ov, flag_s, flag_z, op_done} !== 37'h0) begin
      errors++;
      $display("FAIL R11: reset state got %h expected 0",
               {rd_data, flag_cy, flag_ov, flag_s, flag_z, op_done});
    end
    rst_n = 1;
    for (int i = 0; i < 32; i++) idle(i, "R11");
    // R1 / R2 extends, sign bits both ways
    load(1, 32'h1234_5680, "R1"); exec(op_ext(0, 1), 0, 1, "R1"); idle(1, "R1");
    load(2, 32'hDEAD_BEEF, "R1"); exec(op_ext(2, 2), 0, 2, "R1"); idle(2, "R1");
    load(3, 32'h0000_0080, "R2"); exec(op_ext(1, 3), 0, 3, "R2"); idle(3, "R2");
    load(4, 32'h0000_7F7F, "R2"); exec(op_ext(1, 4), 0, 4, "R2"); idle(4, "R2");
    load(5, 32'h0001_8000, "R2"); exec(op_ext(3, 5), 0, 5, "R2"); idle(5, "R2");
    // R7 flags preserved across extend
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1011, 5, "R10");
    exec(op_ext(1, 5), 0, 5, "R7"); idle(5, "R7");
    // R3 / R6
    load(6, 32'hF0F0_0000, "R3"); load(7, 32'h0F0F_0000, "R3");
    exec(op_rr(6'b001001, 6, 7), 0, 7, "R3"); idle(7, "R6");
    exec(op_rr(6'b001001, 7, 7), 0, 7, "R6"); idle(7, "R6");
    // R4
    load(8, 32'h8000_00FF, "R4");
    exec(op_rr(6'b110101, 8, 9), 16'hFF0F, 9, "R4"); idle(9, "R4");
    exec(op_rr(6'b110101, 0, 10), 16'h8001, 10, "R4"); idle(10, "R4");
    // R5 test leaves registers
    load(11, 32'h8000_0001, "R5"); load(12, 32'h8000_0000, "R5");
    exec(op_rr(6'b001011, 11, 12), 0, 12, "R5"); idle(11, "R5");
    exec(op_rr(6'b001011, 11, 0), 0, 11, "R5"); idle(12, "R5");
    // R6 carry kept with set carry
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1100, 0, "R10");
    exec(op_rr(6'b001001, 11, 12), 0, 12, "R6"); idle(12, "R6");
    // R8 register 0
    load(0, 32'hFFFF_FFFF, "R8"); idle(0, "R8");
    exec(op_rr(6'b001001, 1, 0), 0, 0, "R8"); idle(0, "R8");
    exec(op_rr(6'b110101, 0, 13), 16'h0000, 13, "R8"); idle(13, "R8");
    // R9 unrecognised opcodes
    exec(16'h0860, 0, 1, "R9"); idle(1, "R9");
    exec(16'hFFFF, 0, 31, "R9"); idle(31, "R9");
    exec(op_rr(6'b000100, 3, 3), 0, 3, "R9"); idle(3, "R9");
    // R10 conflicts
    cyc(1, op_rr(6'b001001, 6, 14), 0, 1, 14, 32'h5555_5555, 1, 4'b1111, 14, "R10");
    idle(14, "R10");
    cyc(1, op_ext(0, 15), 0, 1, 16, 32'h1111_2222, 0, 0, 16, "R10");
    idle(15, "R10");
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      logic [15:0] op;
      case (k)
        0: op = op_ext($urandom_range(0, 3), $urandom_range(0, 31));
        1: op = op_rr(6'b001001, $urandom_range(0, 31), $urandom_range(0, 31));
        2: op = op_rr(6'b110101, $urandom_range(0, 31), $urandom_range(0, 31));
        3: op = op_rr(6'b001011, $urandom_range(0, 31), $urandom_range(0, 31));
        default: op = 16'($urandom);
      endcase
      cyc($urandom_range(0, 3) != 0, op, 16'($urandom), $urandom_range(0, 2) == 0,
          5'($urandom), $urandom_range(0, 1) ? 32'($urandom) : 32'h8000_0000,
          $urandom_range(0, 5) == 0, 4'($urandom), 5'($urandom), "R9");
    end
    idle(0, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule